// File: doc/BRIEF.md
# Serial Receive Frame Checker with Trailing-Bit Handling

This block watches the bit-serial receive path of a 10 Mb/s carrier-sense multiple-access MAC. It qualifies each bit with a strobe while the carrier input is high. It screens the preamble for an illegal pattern and finds the start-of-frame delimiter. After the delimiter it assembles data bytes least-significant bit first and runs a serial CRC-32 over every bit. When the carrier drops, it emits one end-of-frame status word. The word holds a frame-check error flag, a framing error flag, and the count of trailing bits that did not make up a whole byte.

The CRC register advances on every received bit, trailing bits included. The value used for the final check is captured only when a byte completes. Between one and seven trailing bits are therefore dropped without touching the check. Eight trailing bits form a real byte and join both the data and the check. Frames with errors are still delivered. Two saturating statistics counters track short (runt) frames and frames that saw a collision.

Control is a four-state machine:
- ST_IDLE waits for carrier and moves to ST_PREAMBLE when the carrier rises.
- ST_PREAMBLE skips the first SKIP_BITS bits, then checks each adjacent bit pair. A "11" pair moves to ST_DATA. A "00" pair moves to ST_DISCARD. A carrier drop returns to ST_IDLE.
- ST_DATA assembles bytes. A carrier drop returns to ST_IDLE and emits the status word.
- ST_DISCARD ignores all bits and returns to ST_IDLE only when the carrier drops.

Top module: `rx_dribble_check`

## Requirements
- R1: After reset, byte_stb, eof_stb, fcs_err, frame_err, dribble_cnt, runt_cnt and coll_cnt are all zero.
- R2: After the start-of-frame delimiter, each group of 8 strobed bits is output on byte_data with the first-received bit in bit 0, together with a one-cycle byte_stb. byte_stb and eof_stb are never high together.
- R3: The CRC-32 (polynomial 0x04C11DB7, preset all ones, MSB-first shift register fed in wire order) is taken over all whole bytes after the delimiter. fcs_err is 1 unless the captured value equals the residue 0xC704DD7B. The frame check sequence is sent on the wire as the complement of the register, bit 31 first.
- R4: One to seven bits after the last whole byte produce no byte_stb and do not change the check. dribble_cnt reports their number, so a frame with a good check and trailing bits has fcs_err=0 and frame_err=0.
- R5: frame_err is 1 exactly when dribble_cnt is between 1 and 7 and fcs_err is 1.
- R6: With zero trailing bits, frame_err is 0 whatever fcs_err is. A frame with a failed check still delivers all its bytes and its eof_stb.
- R7: Eight trailing bits are assembled into a full byte with byte_stb. That byte is included in the check, and dribble_cnt reports 0.
- R8: The first SKIP_BITS preamble bits are ignored, including any "00" among them. A "00" pair seen later in the preamble discards the frame: no byte_stb, no eof_stb and no runt count.
- R9: Once a frame is discarded, later bits, including a "11" pair, are ignored until the carrier goes low.
- R10: At the end of each delivered frame whose whole-byte count is below MIN_FRAME_BYTES, runt_cnt increments by one, saturating at all ones. runt_cnt changes only with eof_stb.
- R11: coll_cnt increments by one, saturating at all ones, each time the carrier drops after a frame attempt during which rx_col was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_crs | input | 1 | Receive carrier; high for the whole frame |
| rx_col | input | 1 | Collision indication |
| rx_bit_en | input | 1 | Qualifies rx_bit for one cycle |
| rx_bit | input | 1 | Serial receive data |
| byte_data | output | 8 | Assembled byte |
| byte_stb | output | 1 | One-cycle pulse when byte_data is new |
| eof_stb | output | 1 | One-cycle end-of-frame pulse |
| fcs_err | output | 1 | Frame check failed (held until next frame end) |
| frame_err | output | 1 | Framing error (held) |
| dribble_cnt | output | 3 | Trailing bits of last frame (held) |
| runt_cnt | output | CNT_W | Saturating runt-frame count |
| coll_cnt | output | CNT_W | Saturating collision-frame count |

## Verification
The bench builds the block with MIN_FRAME_BYTES=16 and CNT_W=3. With these values, frames just above, at and below the runt threshold take only a few hundred bit times. Both statistics counters reach their all-ones ceiling after a handful of short frames or collision bursts, so saturation is exercised as well as counting. SKIP_BITS keeps its default of 8, so the preamble skip window is tested at its normal length.

// File: rtl/rxchk_pkg.sv
package rxchk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_DATA,
        ST_DISCARD
    } rx_state_e;

    localparam logic [31:0] CRC_POLY    = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_PRESET  = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_RESIDUE = 32'hC704_DD7B;

    // One serial step of the MSB-first CRC shift register.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic b);
        logic fb;
        fb = c[31] ^ b;
        return {c[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
    endfunction

endpackage

// File: rtl/rxchk_crc.sv
module rxchk_crc
    import rxchk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        bit_en,
    input  logic        bit_in,
    input  logic        byte_end,
    output logic [31:0] crc_saved
);
    logic [31:0] crc_run;
    logic [31:0] crc_nx;

    assign crc_nx = crc_step(crc_run, bit_in);

    // Running register advances on every bit; the copy used for checking
    // is captured only when the eighth bit of a byte arrives.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            crc_run   <= CRC_PRESET;
            crc_saved <= CRC_PRESET;
        end else if (bit_en) begin
            crc_run <= crc_nx;
            if (byte_end) begin
                crc_saved <= crc_nx;
            end
        end
    end

endmodule

// File: rtl/rxchk_sat_cnt.sv
module rxchk_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (inc && (q != {W{1'b1}})) begin
            q <= q + 1'b1;
        end
    end

endmodule

// File: rtl/rx_dribble_check.sv
module rx_dribble_check
    import rxchk_pkg::*;
#(
    parameter int MIN_FRAME_BYTES = 64,
    parameter int CNT_W           = 8,
    parameter int SKIP_BITS       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_crs,
    input  logic             rx_col,
    input  logic             rx_bit_en,
    input  logic             rx_bit,
    output logic [7:0]       byte_data,
    output logic             byte_stb,
    output logic             eof_stb,
    output logic             fcs_err,
    output logic             frame_err,
    output logic [2:0]       dribble_cnt,
    output logic [CNT_W-1:0] runt_cnt,
    output logic [CNT_W-1:0] coll_cnt
);
    localparam int LEN_W  = $clog2(MIN_FRAME_BYTES + 1);
    localparam int SKIP_W = $clog2(SKIP_BITS + 1);
    localparam logic [LEN_W-1:0]  LEN_MAX  = LEN_W'(MIN_FRAME_BYTES);
    localparam logic [SKIP_W-1:0] SKIP_END = SKIP_W'(SKIP_BITS);

    rx_state_e         state, state_nx;
    logic [SKIP_W-1:0] skip_cnt;
    logic              have_prev;
    logic              prev_bit;
    logic [2:0]        bit_cnt;
    logic [6:0]        shreg;
    logic [LEN_W-1:0]  len_cnt;
    logic              col_seen;
    logic [31:0]       crc_saved;
    logic              skip_done;
    logic              data_bit;
    logic              frame_end;
    logic              check_bad;
    logic              runt_inc;
    logic              coll_inc;

    assign skip_done = (skip_cnt == SKIP_END);
    assign data_bit  = (state == ST_DATA) && rx_crs && rx_bit_en;
    assign frame_end = (state == ST_DATA) && !rx_crs;
    assign check_bad = (crc_saved != CRC_RESIDUE);
    assign runt_inc  = frame_end && (len_cnt < LEN_MAX);
    assign coll_inc  = (state != ST_IDLE) && !rx_crs && (col_seen || rx_col);

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (rx_crs) state_nx = ST_PREAMBLE;
            end
            ST_PREAMBLE: begin
                if (!rx_crs) begin
                    state_nx = ST_IDLE;
                end else if (rx_bit_en && skip_done && have_prev) begin
                    if (!prev_bit && !rx_bit)     state_nx = ST_DISCARD;
                    else if (prev_bit && rx_bit)  state_nx = ST_DATA;
                end
            end
            ST_DATA: begin
                if (!rx_crs) state_nx = ST_IDLE;
            end
            ST_DISCARD: begin
                if (!rx_crs) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_cnt    <= '0;
            have_prev   <= 1'b0;
            prev_bit    <= 1'b0;
            bit_cnt     <= '0;
            shreg       <= '0;
            len_cnt     <= '0;
            col_seen    <= 1'b0;
            byte_data   <= '0;
            byte_stb    <= 1'b0;
            eof_stb     <= 1'b0;
            fcs_err     <= 1'b0;
            frame_err   <= 1'b0;
            dribble_cnt <= '0;
        end else begin
            byte_stb <= 1'b0;
            eof_stb  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    skip_cnt  <= '0;
                    have_prev <= 1'b0;
                    bit_cnt   <= '0;
                    len_cnt   <= '0;
                    col_seen  <= rx_crs && rx_col;
                end
                ST_PREAMBLE: begin
                    col_seen <= col_seen || rx_col;
                    if (rx_bit_en) begin
                        if (!skip_done) begin
                            skip_cnt <= skip_cnt + 1'b1;
                        end else begin
                            have_prev <= 1'b1;
                            prev_bit  <= rx_bit;
                        end
                    end
                end
                ST_DATA: begin
                    col_seen <= col_seen || rx_col;
                    if (!rx_crs) begin
                        eof_stb     <= 1'b1;
                        dribble_cnt <= bit_cnt;
                        fcs_err     <= check_bad;
                        frame_err   <= (bit_cnt != 3'd0) && check_bad;
                    end else if (rx_bit_en) begin
                        shreg   <= {rx_bit, shreg[6:1]};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == 3'd7) begin
                            byte_stb  <= 1'b1;
                            byte_data <= {rx_bit, shreg};
                            if (len_cnt != LEN_MAX) len_cnt <= len_cnt + 1'b1;
                        end
                    end
                end
                ST_DISCARD: begin
                    col_seen <= col_seen || rx_col;
                end
                default: ;
            endcase
        end
    end

    rxchk_crc u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state != ST_DATA),
        .bit_en    (data_bit),
        .bit_in    (rx_bit),
        .byte_end  (bit_cnt == 3'd7),
        .crc_saved (crc_saved)
    );

    rxchk_sat_cnt #(.W(CNT_W)) u_runt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (runt_inc),
        .q     (runt_cnt)
    );

    rxchk_sat_cnt #(.W(CNT_W)) u_coll (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (coll_inc),
        .q     (coll_cnt)
    );

endmodule

// File: rtl/rxchk_sva.sv
module rxchk_sva
    import rxchk_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_crs,
    input rx_state_e        state,
    input logic             byte_stb,
    input logic             eof_stb,
    input logic             fcs_err,
    input logic             frame_err,
    input logic [2:0]       dribble_cnt,
    input logic [CNT_W-1:0] runt_cnt,
    input logic [CNT_W-1:0] coll_cnt
);
    AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_stb && eof_stb)); // R2

    AST_BYTE_NEEDS_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> $past(rx_crs)); // R2

    AST_FRAME_ERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> (fcs_err && dribble_cnt != 3'd0)); // R5

    AST_NO_BYTE_AFTER_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DISCARD) |=> !byte_stb); // R8

    AST_DISCARD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DISCARD && rx_crs) |=> (state == ST_DISCARD)); // R9

    AST_RUNT_ONLY_AT_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        (runt_cnt != $past(runt_cnt)) |-> (eof_stb && runt_cnt == $past(runt_cnt) + 1'b1)); // R10

    AST_RUNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (runt_cnt == {CNT_W{1'b1}}) |=> (runt_cnt == {CNT_W{1'b1}})); // R10

    AST_COLL_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_cnt == {CNT_W{1'b1}}) |=> (coll_cnt == {CNT_W{1'b1}})); // R11

endmodule

bind rx_dribble_check rxchk_sva #(.CNT_W(CNT_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_crs      (rx_crs),
    .state       (state),
    .byte_stb    (byte_stb),
    .eof_stb     (eof_stb),
    .fcs_err     (fcs_err),
    .frame_err   (frame_err),
    .dribble_cnt (dribble_cnt),
    .runt_cnt    (runt_cnt),
    .coll_cnt    (coll_cnt)
);

// File: tb/tb_rx_dribble_check.sv
`timescale 1ns/1ps
module tb_rx_dribble_check;
    localparam int MINB  = 16;
    localparam int CNT_W = 3;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_crs = 1'b0, rx_col = 1'b0, rx_bit_en = 1'b0, rx_bit = 1'b0;
    logic [7:0] byte_data;
    logic byte_stb, eof_stb, fcs_err, frame_err;
    logic [2:0] dribble_cnt;
    logic [CNT_W-1:0] runt_cnt, coll_cnt;

    always #2 clk = ~clk;

    rx_dribble_check #(.MIN_FRAME_BYTES(MINB), .CNT_W(CNT_W), .SKIP_BITS(8)) dut (
        .clk(clk), .rst_n(rst_n), .rx_crs(rx_crs), .rx_col(rx_col),
        .rx_bit_en(rx_bit_en), .rx_bit(rx_bit), .byte_data(byte_data),
        .byte_stb(byte_stb), .eof_stb(eof_stb), .fcs_err(fcs_err),
        .frame_err(frame_err), .dribble_cnt(dribble_cnt),
        .runt_cnt(runt_cnt), .coll_cnt(coll_cnt));

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    logic wb [0:2047];
    logic [7:0] rx_buf [0:511];
    int rx_n = 0;
    int exp_runt = 0, exp_coll = 0;

    // {len[7:0], dribble[2:0], corrupt, extra_byte, collision}
    localparam logic [13:0] VEC [0:8] = '{
        {8'd20, 3'd0, 1'b0, 1'b0, 1'b0},
        {8'd20, 3'd3, 1'b0, 1'b0, 1'b0},
        {8'd20, 3'd7, 1'b1, 1'b0, 1'b0},
        {8'd20, 3'd0, 1'b1, 1'b0, 1'b0},
        {8'd20, 3'd1, 1'b0, 1'b0, 1'b1},
        {8'd20, 3'd0, 1'b0, 1'b1, 1'b0},
        {8'd12, 3'd0, 1'b0, 1'b0, 1'b0},
        {8'd11, 3'd5, 1'b0, 1'b0, 1'b0},
        {8'd3,  3'd2, 1'b1, 1'b0, 1'b0}
    };

    always @(negedge clk) begin
        if (rst_n && byte_stb) begin
            rx_buf[rx_n] = byte_data;
            rx_n = rx_n + 1;
        end
    end

    function automatic logic [31:0] crc_bit(input logic [31:0] c, input logic b);
        return {c[30:0], 1'b0} ^ ((c[31] ^ b) ? 32'h04C11DB7 : 32'h0);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        rx_bit = b;
        rx_bit_en = 1'b1;
        @(negedge clk);
        rx_bit_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_eof(output bit seen);
        seen = 1'b0;
        for (int t = 0; t < 10; t++) begin
            @(negedge clk);
            if (eof_stb) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic send_frame(input int len, input int drib, input bit cor,
                              input bit ext, input bit col, input bit zero_skip);
        logic [31:0] c;
        logic [31:0] c2;
        logic [7:0] b;
        int n, whole, base, nbytes, bad_data;
        bit seen;
        c = '1;
        n = 0;
        for (int i = 0; i < len; i++) begin
            b = 8'((i * 37 + len + 7) & 255);
            for (int j = 0; j < 8; j++) c = crc_bit(c, b[j]);
        end
        for (int i = 0; i < len; i++) begin
            b = 8'((i * 37 + len + 7) & 255);
            if (cor && i == 0) b = b ^ 8'h01;
            for (int j = 0; j < 8; j++) begin wb[n] = b[j]; n++; end
        end
        for (int k = 31; k >= 0; k--) begin wb[n] = ~c[k]; n++; end
        if (ext) begin
            b = 8'hA5;
            for (int j = 0; j < 8; j++) begin wb[n] = b[j]; n++; end
        end
        whole = n;
        for (int d = 0; d < drib; d++) begin wb[n] = (d % 2 == 0); n++; end
        nbytes = whole / 8;
        c2 = '1;
        for (int i = 0; i < whole; i++) c2 = crc_bit(c2, wb[i]);

        rx_col = col;
        rx_crs = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            send_bit(zero_skip ? (i >= 2) : 1'b1);
            send_bit(1'b0);
        end
        for (int i = 0; i < 27; i++) begin send_bit(1'b1); send_bit(1'b0); end
        send_bit(1'b1);
        send_bit(1'b1);
        base = rx_n;
        for (int i = 0; i < n; i++) send_bit(wb[i]);
        rx_crs = 1'b0;
        rx_col = 1'b0;
        wait_eof(seen);

        if (nbytes < MINB && exp_runt < CMAX) exp_runt++;
        if (col && exp_coll < CMAX) exp_coll++;
        bad_data = 0;
        for (int k = 0; k < nbytes && k < 512; k++) begin
            for (int j = 0; j < 8; j++) b[j] = wb[8 * k + j];
            if (rx_buf[base + k] !== b) bad_data++;
        end
        chk("R2 byte count (R4 R7 trailing bits)", 32'(rx_n - base), 32'(nbytes));
        chk("R2 byte values first bit in bit 0", 32'(bad_data), 32'd0);
        chk("R6 eof delivered", 32'(seen), 32'd1);
        chk("R3 fcs_err", {31'd0, fcs_err}, {31'd0, c2 != 32'hC704DD7B});
        chk("R5 frame_err", {31'd0, frame_err},
            {31'd0, (drib != 0) && (c2 != 32'hC704DD7B)});
        chk("R4 dribble_cnt", {29'd0, dribble_cnt}, 32'(drib));
        chk("R10 runt_cnt", {29'd0, runt_cnt}, 32'(exp_runt));
        chk("R11 coll_cnt", {29'd0, coll_cnt}, 32'(exp_coll));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit seen;
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 byte_stb", {31'd0, byte_stb}, 32'd0);
        chk("R1 eof_stb", {31'd0, eof_stb}, 32'd0);
        chk("R1 fcs_err", {31'd0, fcs_err}, 32'd0);
        chk("R1 frame_err", {31'd0, frame_err}, 32'd0);
        chk("R1 dribble_cnt", {29'd0, dribble_cnt}, 32'd0);
        chk("R1 runt_cnt", {29'd0, runt_cnt}, 32'd0);
        chk("R1 coll_cnt", {29'd0, coll_cnt}, 32'd0);

        // Vector table: R3 R4 R5 R6 R7 R10 R11
        for (int v = 0; v < 9; v++) begin
            send_frame(int'(VEC[v][13:6]), int'(VEC[v][5:3]), VEC[v][2],
                       VEC[v][1], VEC[v][0], 1'b0);
            repeat (4) @(negedge clk);
        end

        // R8: "00" inside the skip window is ignored, frame received normally
        send_frame(20, 0, 1'b0, 1'b0, 1'b0, 1'b1);
        repeat (4) @(negedge clk);

        // R8 R9: "00" after the skip window discards; later "11" and data ignored
        base = rx_n;
        rx_crs = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin send_bit(1'b1); send_bit(1'b0); end
        send_bit(1'b0);
        for (int i = 0; i < 6; i++) begin send_bit(1'b1); send_bit(1'b0); end
        send_bit(1'b1);
        send_bit(1'b1);
        for (int i = 0; i < 160; i++) send_bit(i[0] ^ i[3]);
        rx_crs = 1'b0;
        wait_eof(seen);
        chk("R9 no bytes after discard", 32'(rx_n - base), 32'd0);
        chk("R8 no eof on discarded frame", 32'(seen), 32'd0);
        chk("R8 runt_cnt unchanged by discard", {29'd0, runt_cnt}, 32'(exp_runt));
        repeat (4) @(negedge clk);
        // Reception resumes after carrier loss
        send_frame(20, 0, 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (4) @(negedge clk);

        // R10 saturation with runt frames
        for (int i = 0; i < 8; i++) begin
            send_frame(2, 0, 1'b0, 1'b0, 1'b0, 1'b0);
            repeat (4) @(negedge clk);
        end
        chk("R10 runt_cnt saturated", {29'd0, runt_cnt}, 32'(CMAX));

        // R11 saturation with short collision bursts
        for (int i = 0; i < 9; i++) begin
            rx_crs = 1'b1;
            rx_col = 1'b1;
            @(negedge clk);
            for (int k = 0; k < 4; k++) send_bit(k[0]);
            rx_crs = 1'b0;
            rx_col = 1'b0;
            repeat (4) @(negedge clk);
            if (exp_coll < CMAX) exp_coll++;
            chk("R11 coll_cnt after burst", {29'd0, coll_cnt}, 32'(exp_coll));
        end
        chk("R11 coll_cnt saturated", {29'd0, coll_cnt}, 32'(CMAX));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule